// File: doc/BRIEF.md
# Floppy Controller Bus Glue with Wait-State Pacing

This block sits between a host CPU bus and a byte-wide floppy disk controller on an expansion card. The host first presents an address together with the card-select and ROM-window lines and pulses an address strobe. The block captures that address phase and decides whether the access targets the controller's register file or the card ROM. Read and write strobes that follow then go to the controller only for qualified address patterns. All other reads in the window return the ROM byte. All other writes are dropped. Data crossing to and from the controller is bit-inverted.

The block also drives the host READY line. When the wait function is armed and the captured address points at the controller, READY is pulled low for as long as the controller has no data byte and no interrupt pending and the drive motor is spinning. This holds the CPU in wait states until each byte is available, so a tight transfer loop is paced byte by byte. READY is combinational. It releases in the same cycle that any of these conditions lapses.

Top module: `fdc_bus_glue`

## Requirements
- R1: A captured access selects the controller only when the card select and the window select were both high at the address strobe and (address AND 0x1FF1) equals 0x1FF0.
- R2: While the controller is selected and address bits 3 and 0 are both 0, a read strobe raises the controller read strobe, and the host read data is the bitwise complement of the controller's data byte.
- R3: Every other read inside the window (card and window selected) returns the ROM byte, and the ROM address output equals the captured address AND 0x1FFF.
- R4: A write strobe raises the controller write strobe only while the controller is selected, address bit 3 is 1 and address bit 0 is 0. Any other write produces no controller strobe.
- R5: The controller register index output equals captured address bits 2:1.
- R6: The byte sent to the controller on a write is the bitwise complement of the host write byte.
- R7: READY is 0 exactly when the controller is selected, the wait enable is set, DRQ is 0, INTRQ is 0 and the motor flag is 1. Otherwise READY is 1.
- R8: READY returns to 1 in the same cycle that DRQ or INTRQ rises or the motor flag falls, with no clock edge in between. Clearing the wait enable releases READY after the clock edge that loads it.
- R9: After reset the controller-select state and the wait enable are cleared, so READY is 1.
- R10: An access captured outside the window, or with the card deselected, raises no controller strobe and returns read data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| addr_stb | input | 1 | Captures the address phase |
| addr | input | 16 | Host address |
| win_sel | input | 1 | Access lies in the card ROM window |
| card_sel | input | 1 | Card is selected |
| rd_stb | input | 1 | Host read strobe |
| wr_stb | input | 1 | Host write strobe |
| wdata | input | 8 | Host write byte |
| rdata | output | 8 | Host read byte |
| wait_ld | input | 1 | Loads the wait enable |
| wait_val | input | 1 | Value loaded into the wait enable |
| drq | input | 1 | Controller data request |
| intrq | input | 1 | Controller interrupt request |
| motor_on | input | 1 | Drive motor running |
| ready | output | 1 | Host READY, low inserts wait states |
| ctl_idx | output | 2 | Controller register index |
| ctl_rd | output | 1 | Controller read strobe |
| ctl_wr | output | 1 | Controller write strobe |
| ctl_wdata | output | 8 | Byte to the controller |
| ctl_rdata | input | 8 | Byte from the controller |
| rom_addr | output | 13 | Card ROM address |
| rom_data | input | 8 | Card ROM byte |

## Verification
Two things can happen in the same cycle: a controller read strobe is active while READY releases because DRQ has just risen. The bench provokes this by holding a read on a selected controller address with waits armed. It raises DRQ without any clock edge in between, then checks that READY has gone high and that the controller read strobe and the inverted data are already present in that same sample. The same kind of check is repeated for INTRQ rising and for the motor flag dropping.

// File: rtl/fdc_bus_glue.sv
module fdc_bus_glue #(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 8,
  parameter int ROM_AW  = 13,
  parameter int IDX_W   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_stb,
  input  logic [ADDR_W-1:0] addr,
  input  logic              win_sel,
  input  logic              card_sel,
  input  logic              rd_stb,
  input  logic              wr_stb,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              wait_ld,
  input  logic              wait_val,
  input  logic              drq,
  input  logic              intrq,
  input  logic              motor_on,
  output logic              ready,
  output logic [IDX_W-1:0]  ctl_idx,
  output logic              ctl_rd,
  output logic              ctl_wr,
  output logic [DATA_W-1:0] ctl_wdata,
  input  logic [DATA_W-1:0] ctl_rdata,
  output logic [ROM_AW-1:0] rom_addr,
  input  logic [DATA_W-1:0] rom_data
);
  localparam logic [ADDR_W-1:0] SEL_MASK  = ADDR_W'(16'h1FF1);
  localparam logic [ADDR_W-1:0] SEL_MATCH = ADDR_W'(16'h1FF0);

  logic [ADDR_W-1:0] addr_q;
  logic              inwin_q;
  logic              ctl_sel_q;
  logic              wait_en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      addr_q    <= '0;
      inwin_q   <= 1'b0;
      ctl_sel_q <= 1'b0;
      wait_en_q <= 1'b0;
    end else begin
      if (addr_stb) begin
        addr_q    <= addr;
        inwin_q   <= win_sel && card_sel;
        ctl_sel_q <= win_sel && card_sel && ((addr & SEL_MASK) == SEL_MATCH);
      end
      if (wait_ld) wait_en_q <= wait_val;
    end
  end

  logic rd_port, wr_port;
  assign rd_port = ctl_sel_q && !addr_q[3] && !addr_q[0];
  assign wr_port = ctl_sel_q &&  addr_q[3] && !addr_q[0];

  assign ctl_idx   = addr_q[IDX_W:1];
  assign ctl_rd    = rd_stb && rd_port;
  assign ctl_wr    = wr_stb && wr_port;
  assign ctl_wdata = ~wdata;
  assign rom_addr  = addr_q[ROM_AW-1:0];

  always_comb begin
    if (!inwin_q)     rdata = '0;
    else if (rd_port) rdata = ~ctl_rdata;
    else              rdata = rom_data;
  end

  assign ready = !(ctl_sel_q && wait_en_q && !drq && !intrq && motor_on);

  assert_wait_cause_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (!drq && !intrq && motor_on && wait_en_q));
  assert_sel_in_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_sel_q |-> inwin_q);
  assert_single_strobe_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({ctl_rd, ctl_wr}));
  assert_outside_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !inwin_q |-> (rdata == '0 && !ctl_rd && !ctl_wr));
  assert_wr_pattern_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_wr |-> (wr_stb && addr_q[3] && !addr_q[0]));
  assert_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (drq || intrq || !motor_on) |-> ready);
endmodule

// File: tb/tb_fdc_bus_glue.sv
module tb_fdc_bus_glue;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, addr_stb, win_sel, card_sel, rd_stb, wr_stb;
  logic wait_ld, wait_val, drq, intrq, motor_on;
  logic [15:0] addr;
  logic [7:0] wdata, rdata, ctl_wdata, ctl_rdata, rom_data;
  logic ready, ctl_rd, ctl_wr;
  logic [1:0] ctl_idx;
  logic [12:0] rom_addr;

  int checks = 0, fails = 0;
  bit done = 0;

  fdc_bus_glue dut (.*);

  assign rom_data = rom_addr[7:0] ^ 8'h5A ^ {3'b000, rom_addr[12:8]};

  function automatic logic [7:0] rom_model(input logic [15:0] a);
    logic [12:0] r = a[12:0];
    return r[7:0] ^ 8'h5A ^ {3'b000, r[12:8]};
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic capture(input logic [15:0] a, input logic w, input logic c);
    @(negedge clk);
    addr = a; win_sel = w; card_sel = c; addr_stb = 1;
    @(negedge clk);
    addr_stb = 0;
  endtask

  task automatic arm(input logic v);
    @(negedge clk);
    wait_ld = 1; wait_val = v;
    @(negedge clk);
    wait_ld = 0;
  endtask

  task automatic do_read(output logic [7:0] d, output logic s);
    rd_stb = 1; #1;
    d = rdata; s = ctl_rd;
    chk("R4 no write strobe on read", {15'd0, ctl_wr}, 16'd0);
    rd_stb = 0; #1;
  endtask

  task automatic do_write(input logic [7:0] v, output logic s);
    wdata = v; wr_stb = 1; #1;
    s = ctl_wr;
    chk("R6 inverted write data", {8'd0, ctl_wdata}, {8'd0, ~v});
    chk("R4 no read strobe on write", {15'd0, ctl_rd}, 16'd0);
    wr_stb = 0; #1;
  endtask

  task automatic t_reset;
    rst_n = 0; addr_stb = 0; win_sel = 0; card_sel = 0; rd_stb = 0; wr_stb = 0;
    wait_ld = 0; wait_val = 0; drq = 0; intrq = 0; motor_on = 1; addr = 0; wdata = 0;
    ctl_rdata = 8'h3C;
    repeat (3) @(negedge clk);
    chk("R9 ready during reset", {15'd0, ready}, 16'd1);
    rst_n = 1;
    @(negedge clk);
    chk("R9 ready after reset", {15'd0, ready}, 16'd1);
    chk("R9 rdata after reset", {8'd0, rdata}, 16'd0);
  endtask

  task automatic t_ctl_read;
    logic [7:0] d; logic s;
    for (int i = 0; i < 4; i++) begin
      capture(16'h5FF0 | 16'(i << 1), 1, 1);
      ctl_rdata = 8'h11 * 8'(i + 1);
      do_read(d, s);
      chk("R2 ctl read strobe", {15'd0, s}, 16'd1);
      chk("R2 inverted read data", {8'd0, d}, {8'd0, ~(8'h11 * 8'(i + 1))});
      chk("R5 register index", {14'd0, ctl_idx}, 16'(i));
    end
  endtask

  task automatic t_rom_read;
    logic [7:0] d; logic s;
    logic [15:0] al [4] = '{16'h5FF8, 16'h5FF1, 16'h4000, 16'h5ABC};
    foreach (al[k]) begin
      capture(al[k], 1, 1);
      do_read(d, s);
      chk("R3 no ctl strobe on ROM read", {15'd0, s}, 16'd0);
      chk("R3 ROM address", {3'd0, rom_addr}, al[k] & 16'h1FFF);
      chk("R3 ROM data", {8'd0, d}, {8'd0, rom_model(al[k])});
    end
  endtask

  task automatic t_writes;
    logic s;
    capture(16'h5FFA, 1, 1);
    do_write(8'hA5, s);
    chk("R4 ctl write strobe", {15'd0, s}, 16'd1);
    chk("R5 write index", {14'd0, ctl_idx}, 16'd1);
    capture(16'h5FFE, 1, 1);
    do_write(8'h0F, s);
    chk("R4 ctl write strobe idx3", {15'd0, s}, 16'd1);
    chk("R5 write index 3", {14'd0, ctl_idx}, 16'd3);
    capture(16'h5FF0, 1, 1);
    do_write(8'h12, s);
    chk("R4 write dropped bit3=0", {15'd0, s}, 16'd0);
    capture(16'h5FF9, 1, 1);
    do_write(8'h34, s);
    chk("R4 write dropped bit0=1", {15'd0, s}, 16'd0);
    capture(16'h4008, 1, 1);
    do_write(8'h56, s);
    chk("R1 write dropped off-decode", {15'd0, s}, 16'd0);
  endtask

  task automatic t_outside;
    logic [7:0] d; logic s;
    capture(16'h5FF0, 0, 1);
    do_read(d, s);
    chk("R10 no window read data", {8'd0, d}, 16'd0);
    chk("R10 no window ctl strobe", {15'd0, s}, 16'd0);
    do_write(8'h77, s);
    chk("R10 no window write strobe", {15'd0, s}, 16'd0);
    capture(16'h5FF8, 1, 0);
    do_read(d, s);
    chk("R10 card off read data", {8'd0, d}, 16'd0);
    do_write(8'h77, s);
    chk("R10 card off write strobe", {15'd0, s}, 16'd0);
  endtask

  task automatic t_ready;
    logic [7:0] d; logic s;
    drq = 0; intrq = 0; motor_on = 1;
    capture(16'h5FF6, 1, 1);
    #1 chk("R7 ready with wait disarmed", {15'd0, ready}, 16'd1);
    arm(1);
    #1 chk("R7 ready low when waiting", {15'd0, ready}, 16'd0);
    rd_stb = 1; ctl_rdata = 8'hC3; #1;
    chk("R7 still waiting during read", {15'd0, ready}, 16'd0);
    drq = 1; #1;
    chk("R8 ready on drq same cycle", {15'd0, ready}, 16'd1);
    chk("R8 read strobe with release", {15'd0, ctl_rd}, 16'd1);
    chk("R8 data with release", {8'd0, rdata}, 16'h003C);
    rd_stb = 0; drq = 0; #1;
    chk("R7 low again", {15'd0, ready}, 16'd0);
    intrq = 1; #1;
    chk("R8 ready on intrq", {15'd0, ready}, 16'd1);
    intrq = 0; #1;
    motor_on = 0; #1;
    chk("R8 ready on motor stop", {15'd0, ready}, 16'd1);
    motor_on = 1; #1;
    capture(16'h5FF1, 1, 1);
    #1 chk("R1 no wait off-decode", {15'd0, ready}, 16'd1);
    capture(16'h7FF0, 1, 1);
    #1 chk("R1 selected 0x7FF0", {15'd0, ready}, 16'd0);
    capture(16'h5FF0, 1, 0);
    #1 chk("R1 no wait card off", {15'd0, ready}, 16'd1);
    capture(16'h5FF0, 1, 1);
    #1 chk("R7 low before disarm", {15'd0, ready}, 16'd0);
    arm(0);
    #1 chk("R8 ready after disarm", {15'd0, ready}, 16'd1);
    arm(1);
    @(negedge clk); rst_n = 0;
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk("R9 reset clears wait state", {15'd0, ready}, 16'd1);
    do_read(d, s);
    chk("R9 reset clears selection", {15'd0, s}, 16'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_ctl_read();
    t_rom_read();
    t_writes();
    t_outside();
    t_ready();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule